// File: doc/BRIEF.md
# TDM Backplane Clock and Frame Pulse Generator

This block turns one 65.536 MHz master clock into a coherent set of timing signals for a time-division-multiplexed backplane. It produces three divided clocks and three 8 kHz frame pulses. The divided clocks are a 2.048 MHz clock, a 16.384 MHz clock, and a third clock that is either 8.192 MHz or 32.768 MHz. The three frame pulses mark the start of every 125 us frame, and each has its own width and polarity. All outputs are decoded from one free-running 13-bit frame counter, so every output keeps a fixed phase to every other.

A static rate select picks the lower-rate or higher-rate mode. It changes the selectable clock and the widths of two of the pulses. The select is captured at mid-frame and takes effect at the next frame boundary, so a mode change never cuts a pulse or a clock phase short. The synchronous reset forces every output to its idle level. The enable freezes the whole block in place.

Top module: `tdm_timing_gen`

In what follows, "count" is the frame counter value. Each output reflects the count held in the same cycle. Reset sets the count to 0, and each enabled master cycle advances it by one, modulo 8192. The frame boundary is count 0.

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it, `clk2_o`, `clk16_o`, `clk_sel_o` and `fp_hi_o` are 0 and `fpn_wide_o` and `fpn_narrow_o` are 1.
- R2: `clk2_o` is high exactly when count mod 32 is below 16. This gives a 50% duty, a period of 32 master cycles, and a rising edge at count 0.
- R3: `clk16_o` is high exactly when count mod 4 is below 2.
- R4: `clk_sel_o` is high exactly when count mod P is below P/2. P is 8 in the low-rate mode (select 0) and 2 in the high-rate mode (select 1).
- R5: `fp_hi_o` is active high. It lasts W = 8 cycles in the low-rate mode and W = 2 in the high-rate mode. It covers the last floor(W/2) counts of a frame and the first W - floor(W/2) counts of the next.
- R6: `fpn_wide_o` is active low. Its width is 16 cycles in the low-rate mode and 1 cycle in the high-rate mode, and it is placed by the rule of R5. In the 1-cycle case it is low only at count 0.
- R7: `fpn_narrow_o` is active low and 4 cycles wide in both modes: counts 8190, 8191, 0 and 1.
- R8: Each frame pulse repeats every 8192 enabled master cycles (8 kHz).
- R9: `sel_i` is sampled in the cycle where the count steps to 4096. From that point the sampled value sets the pulse widths. From the next count 0 it also sets the `clk_sel_o` rate. A select change after that sampling point waits one more frame. Reset loads the select directly.
- R10: While `en_i` is low and reset is not asserted, the count and every output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 65.536 MHz master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the block |
| sel_i | input | 1 | Rate select: 0 low-rate, 1 high-rate |
| clk2_o | output | 1 | 2.048 MHz clock |
| clk16_o | output | 1 | 16.384 MHz clock |
| clk_sel_o | output | 1 | 8.192 MHz or 32.768 MHz clock |
| fp_hi_o | output | 1 | Active-high frame pulse, 8 or 2 cycles |
| fpn_wide_o | output | 1 | Active-low frame pulse, 16 or 1 cycles |
| fpn_narrow_o | output | 1 | Active-low frame pulse, 4 cycles |

## Verification
The bench keeps its own frame count and compares all six outputs in every cycle over several full frames. These frames cover a steady low-rate mode, a steady high-rate mode, and select changes made just before and just after the mid-frame sampling point. The two cases of select change show whether the rate switch lands on the correct boundary or one frame late. Stretches with `en_i` toggling irregularly across a frame boundary separate a true freeze from a counter that slips. A reset in the middle of a frame, with the select already high, shows that reset loads the mode without waiting for a boundary.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

   typedef enum logic {
      MODE_LO = 1'b0,
      MODE_HI = 1'b1
   } tfg_mode_e;

   // True when count c lies in a window of width w straddling the wrap of an n-count frame
   function automatic logic tfg_in_window(int c, int w, int n);
      int pre;
      int post;
      pre  = w / 2;
      post = w - pre;
      return (c < post) || ((pre > 0) && (c >= n - pre));
   endfunction

endpackage

// File: rtl/tfg_frame_ctr.sv
module tfg_frame_ctr
   import tfg_pkg::*;
#(
   parameter int CNT_W = 13
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             sel_i,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output tfg_mode_e        pend_q,
   output tfg_mode_e        mode_nxt
);

   localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   tfg_mode_e mode_q;

   always_comb begin
      cnt_nxt  = cnt_q + CNT_W'(1);
      mode_nxt = (cnt_nxt == ZERO) ? pend_q : mode_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= ZERO;
         pend_q <= tfg_mode_e'(sel_i);
         mode_q <= tfg_mode_e'(sel_i);
      end else if (en_i) begin
         cnt_q <= cnt_nxt;
         if (cnt_nxt == HALF) begin
            pend_q <= tfg_mode_e'(sel_i);
         end
         if (cnt_nxt == ZERO) begin
            mode_q <= pend_q;
         end
      end
   end

endmodule

// File: rtl/tfg_clk_div.sv
module tfg_clk_div
   import tfg_pkg::*;
#(
   parameter int CNT_W  = 13,
   parameter int DIV_LO = 8,
   parameter int DIV_HI = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  tfg_mode_e        mode_nxt,
   output logic             clk_o
);

   localparam int BIT_LO = $clog2(DIV_LO) - 1;
   localparam int BIT_HI = $clog2(DIV_HI) - 1;

   logic lvl;

   generate
      if (DIV_LO == DIV_HI) begin : g_fixed
         always_comb lvl = ~cnt_nxt[BIT_LO];
      end else begin : g_muxed
         always_comb lvl = (mode_nxt == MODE_HI) ? ~cnt_nxt[BIT_HI] : ~cnt_nxt[BIT_LO];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         clk_o <= 1'b0;
      end else if (en_i) begin
         clk_o <= lvl;
      end
   end

endmodule

// File: rtl/tfg_pulse.sv
module tfg_pulse
   import tfg_pkg::*;
#(
   parameter int CNT_W    = 13,
   parameter int W_LO     = 8,
   parameter int W_HI     = 2,
   parameter bit ACT_HIGH = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  tfg_mode_e        mode,
   output logic             pulse_o
);

   localparam int  N_CNT = 1 << CNT_W;
   localparam logic IDLE = ~ACT_HIGH;

   logic act;
   logic lvl;

   generate
      if (W_LO == W_HI) begin : g_fixed
         always_comb act = tfg_in_window(int'(cnt_nxt), W_LO, N_CNT);
      end else begin : g_muxed
         always_comb act = (mode == MODE_HI) ? tfg_in_window(int'(cnt_nxt), W_HI, N_CNT)
                                             : tfg_in_window(int'(cnt_nxt), W_LO, N_CNT);
      end
      if (ACT_HIGH) begin : g_high
         always_comb lvl = act;
      end else begin : g_low
         always_comb lvl = ~act;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pulse_o <= IDLE;
      end else if (en_i) begin
         pulse_o <= lvl;
      end
   end

endmodule

// File: rtl/tdm_timing_gen.sv
module tdm_timing_gen
   import tfg_pkg::*;
#(
   parameter int CNT_W       = 13,
   parameter int CLKA_DIV    = 32,
   parameter int CLKB_DIV    = 4,
   parameter int CLKS_DIV_LO = 8,
   parameter int CLKS_DIV_HI = 2,
   parameter int FPH_W_LO    = 8,
   parameter int FPH_W_HI    = 2,
   parameter int FPW_W_LO    = 16,
   parameter int FPW_W_HI    = 1,
   parameter int FPN_W       = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic sel_i,
   output logic clk2_o,
   output logic clk16_o,
   output logic clk_sel_o,
   output logic fp_hi_o,
   output logic fpn_wide_o,
   output logic fpn_narrow_o
);

   localparam int N_CNT  = 1 << CNT_W;
   localparam int HALF_N = N_CNT / 2;

   initial begin : p_param_chk
      assert (CNT_W >= 4) else $error("CNT_W too small");
      assert ((CLKA_DIV >= 2) && ((CLKA_DIV & (CLKA_DIV - 1)) == 0) && (CLKA_DIV <= N_CNT))
         else $error("CLKA_DIV must be a power of two within the frame");
      assert ((CLKB_DIV >= 2) && ((CLKB_DIV & (CLKB_DIV - 1)) == 0) && (CLKB_DIV <= N_CNT))
         else $error("CLKB_DIV must be a power of two within the frame");
      assert ((CLKS_DIV_LO >= 2) && ((CLKS_DIV_LO & (CLKS_DIV_LO - 1)) == 0))
         else $error("CLKS_DIV_LO must be a power of two");
      assert ((CLKS_DIV_HI >= 2) && ((CLKS_DIV_HI & (CLKS_DIV_HI - 1)) == 0))
         else $error("CLKS_DIV_HI must be a power of two");
      assert ((FPH_W_LO >= 1) && (FPH_W_LO < HALF_N) && (FPH_W_HI >= 1) && (FPH_W_HI < HALF_N))
         else $error("high pulse widths must fit inside half a frame");
      assert ((FPW_W_LO >= 1) && (FPW_W_LO < HALF_N) && (FPW_W_HI >= 1) && (FPW_W_HI < HALF_N))
         else $error("wide pulse widths must fit inside half a frame");
      assert ((FPN_W >= 1) && (FPN_W < HALF_N))
         else $error("narrow pulse width must fit inside half a frame");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   tfg_mode_e        pend_q;
   tfg_mode_e        mode_nxt;

   tfg_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .sel_i    (sel_i),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .pend_q   (pend_q),
      .mode_nxt (mode_nxt)
   );

   tfg_clk_div #(.CNT_W(CNT_W), .DIV_LO(CLKA_DIV), .DIV_HI(CLKA_DIV)) u_clk2 (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode_nxt (mode_nxt), .clk_o (clk2_o)
   );

   tfg_clk_div #(.CNT_W(CNT_W), .DIV_LO(CLKB_DIV), .DIV_HI(CLKB_DIV)) u_clk16 (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode_nxt (mode_nxt), .clk_o (clk16_o)
   );

   tfg_clk_div #(.CNT_W(CNT_W), .DIV_LO(CLKS_DIV_LO), .DIV_HI(CLKS_DIV_HI)) u_clksel (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode_nxt (mode_nxt), .clk_o (clk_sel_o)
   );

   tfg_pulse #(.CNT_W(CNT_W), .W_LO(FPH_W_LO), .W_HI(FPH_W_HI), .ACT_HIGH(1'b1)) u_fph (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode (pend_q), .pulse_o (fp_hi_o)
   );

   tfg_pulse #(.CNT_W(CNT_W), .W_LO(FPW_W_LO), .W_HI(FPW_W_HI), .ACT_HIGH(1'b0)) u_fpw (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode (pend_q), .pulse_o (fpn_wide_o)
   );

   tfg_pulse #(.CNT_W(CNT_W), .W_LO(FPN_W), .W_HI(FPN_W), .ACT_HIGH(1'b0)) u_fpn (
      .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
      .cnt_nxt (cnt_nxt), .mode (pend_q), .pulse_o (fpn_narrow_o)
   );

endmodule

// File: rtl/tdm_timing_gen_chk.sv
module tdm_timing_gen_chk #(
   parameter int CNT_W = 13
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             en_i,
   input logic [CNT_W-1:0] cnt_q,
   input logic             clk2_o,
   input logic             clk16_o,
   input logic             clk_sel_o,
   input logic             fp_hi_o,
   input logic             fpn_wide_o,
   input logic             fpn_narrow_o
);

   AST_PULSE_NESTING: assert property (@(posedge clk_i) disable iff (rst_i)
      fp_hi_o |-> (!fpn_narrow_o || !fpn_wide_o)); // R5

   AST_CLK_COHERENT: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(clk2_o) |-> $rose(clk16_o)); // R2

   AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(clk2_o) && $stable(clk16_o) && $stable(clk_sel_o) &&
                 $stable(fp_hi_o) && $stable(fpn_wide_o) && $stable(fpn_narrow_o))); // R10

   AST_FRAME_START: assert property (@(posedge clk_i) disable iff (rst_i)
      ((cnt_q == '0) && ($past(cnt_q) != '0)) |->
         (fp_hi_o && !fpn_wide_o && !fpn_narrow_o && clk2_o && clk16_o && clk_sel_o)); // R8

endmodule

bind tdm_timing_gen tdm_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .en_i         (en_i),
   .cnt_q        (cnt_q),
   .clk2_o       (clk2_o),
   .clk16_o      (clk16_o),
   .clk_sel_o    (clk_sel_o),
   .fp_hi_o      (fp_hi_o),
   .fpn_wide_o   (fpn_wide_o),
   .fpn_narrow_o (fpn_narrow_o)
);

// File: tb/tdm_timing_gen_bench.sv
module tdm_timing_gen_bench;

   localparam int N_CNT = 8192;

   logic clk = 1'b0;
   logic rst_i = 1'b1;
   logic en_i = 1'b1;
   logic sel_i = 1'b0;
   logic clk2_o, clk16_o, clk_sel_o, fp_hi_o, fpn_wide_o, fpn_narrow_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string phase = "R1";

   // model state
   int m_cnt  = 0;
   bit m_pend = 1'b0;
   bit m_mode = 1'b0;
   bit m_idle = 1'b1;
   bit m_idle_prev = 1'b1;

   always #2.5 clk = ~clk;

   tdm_timing_gen u_tdm_timing_gen (
      .clk_i        (clk),
      .rst_i        (rst_i),
      .en_i         (en_i),
      .sel_i        (sel_i),
      .clk2_o       (clk2_o),
      .clk16_o      (clk16_o),
      .clk_sel_o    (clk_sel_o),
      .fp_hi_o      (fp_hi_o),
      .fpn_wide_o   (fpn_wide_o),
      .fpn_narrow_o (fpn_narrow_o)
   );

   function automatic bit clk_lvl(int c, int p);
      return (c % p) < (p / 2);
   endfunction

   function automatic bit win(int c, int w);
      int pre;
      int post;
      pre  = w / 2;
      post = w - pre;
      return (c < post) || ((pre > 0) && (c >= N_CNT - pre));
   endfunction

   always @(posedge clk) begin
      if (rst_i) begin
         m_cnt  = 0;
         m_pend = sel_i;
         m_mode = sel_i;
         m_idle = 1'b1;
      end else if (en_i) begin
         m_cnt = (m_cnt + 1) % N_CNT;
         if (m_cnt == N_CNT / 2) m_pend = sel_i;
         if (m_cnt == 0) m_mode = m_pend;
         m_idle = 1'b0;
      end
   end

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] count=%0d actual=%b expected=%b", req, phase, m_cnt, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (m_idle) begin
            chk("R1 clk2", clk2_o, 1'b0);
            chk("R1 clk16", clk16_o, 1'b0);
            chk("R1 clksel", clk_sel_o, 1'b0);
            chk("R1 fp_hi", fp_hi_o, 1'b0);
            chk("R1 fpn_wide", fpn_wide_o, 1'b1);
            chk("R1 fpn_narrow", fpn_narrow_o, 1'b1);
         end else begin
            chk("R2 clk2", clk2_o, clk_lvl(m_cnt, 32));
            chk("R3 clk16", clk16_o, clk_lvl(m_cnt, 4));
            chk("R4 clksel", clk_sel_o, clk_lvl(m_cnt, m_mode ? 2 : 8));
            chk("R5 R8 fp_hi", fp_hi_o, win(m_cnt, m_pend ? 2 : 8));
            chk("R6 R8 fpn_wide", fpn_wide_o, !win(m_cnt, m_pend ? 1 : 16));
            chk("R7 R8 fpn_narrow", fpn_narrow_o, !win(m_cnt, 4));
         end
      end
   end

   task automatic run_to(int c);
      @(negedge clk);
      while (m_cnt != c) @(negedge clk);
   endtask

   initial begin : p_stim
      repeat (4) @(negedge clk);
      // low-rate mode, two boundaries
      phase = "R2";
      rst_i = 1'b0;
      run_to(0);
      run_to(200);
      // select rises before the mid-frame sample point
      phase = "R9";
      sel_i = 1'b1;
      run_to(4096);
      run_to(4097);
      sel_i = 1'b0;           // after sample point: must wait one more frame
      run_to(0);
      run_to(300);
      run_to(0);
      run_to(300);
      // irregular enable across a boundary
      phase = "R10";
      run_to(8000);
      for (int i = 0; i < 900; i++) begin
         en_i = ((i % 3) != 0) && ((i % 7) != 5);
         @(negedge clk);
      end
      en_i = 1'b1;
      // mid-frame reset with select high
      phase = "R1";
      sel_i = 1'b1;
      run_to(2500);
      rst_i = 1'b1;
      repeat (3) @(negedge clk);
      rst_i = 1'b0;
      phase = "R9";
      run_to(0);
      run_to(0);
      run_to(50);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : p_watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule